// File: doc/BRIEF.md
# Binarized Fully Connected Layer Engine

This block evaluates one fully connected layer in which weights, input activations and output activations are all single bits. For each output neuron it forms the bitwise XNOR of the neuron's weight row with the input vector. It then counts the ones in that result and compares the count against a per-neuron threshold. The comparison stands in for the batch normalisation and sign steps. Its result is the neuron's output bit.

The hardware has `PES` processing elements, each with `LANES` bit lanes. The matrix of `ROWS` neurons by `COLS` synapses is folded in time. A tile of `PES` rows by `LANES` columns is handled each cycle, so one vector costs `(ROWS/PES)*(COLS/LANES)` cycles. Each element holds its own share of the weight rows and thresholds in local storage, and keeps its own accumulator.

Input vectors arrive `LANES` bits per beat on a valid/ready stream, and each vector is sent exactly once. The block keeps a copy of the vector and replays it for the remaining neuron groups. Each neuron group leaves as one `PES`-bit beat on a valid/ready output stream. Weights and thresholds are written through a plain write port before inference starts.

Top module: `bmv_unit`

## Requirements
- R1: For neuron r and input vector v, the output bit is 1 exactly when the number of positions c with weight[r][c] equal to v[c] is at least threshold[r]. The comparison is unsigned and `$clog2(COLS)+1` bits wide.
- R2: Row r is served by element r mod `PES` in neuron group r / `PES`. Within an output beat, bit p holds the result for row group*`PES`+p. The beats of one vector leave in ascending group order, `ROWS/PES` beats per vector.
- R3: A weight write with row r, chunk k and data d sets weight[r][k*`LANES`+l] to d[l]. A threshold write with row r sets threshold[r]. Input beat k of a vector carries v[k*`LANES`+l] on bit l.
- R4: `inReady` is high only while the first neuron group is being computed. Exactly `COLS/LANES` beats are taken per vector, and `inReady` stays low while the stored vector is replayed for the other groups.
- R5: When input is always valid and output is always ready, consecutive output beats are exactly `COLS/LANES` cycles apart, including across vector boundaries. No cycle is lost between vectors.
- R6: While `outValid` is high and `outReady` is low, `outValid` stays high and `outBits` does not change. No result is dropped or overwritten.
- R7: A threshold of 0 always gives 1. A threshold equal to the match count gives 1, and a threshold one above it gives 0, including the all-match count `COLS` and the zero-match count.
- R8: During reset `outValid` is 0 and `inReady` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wgtWe | input | 1 | Weight write strobe |
| wgtRow | input | $clog2(ROWS) | Neuron row of the weight write |
| wgtChunk | input | $clog2(COLS/LANES) | Column chunk of the weight write |
| wgtData | input | LANES | Weight bits for the chunk |
| thrWe | input | 1 | Threshold write strobe |
| thrRow | input | $clog2(ROWS) | Neuron row of the threshold write |
| thrData | input | $clog2(COLS)+1 | Threshold value |
| inValid | input | 1 | Input beat valid |
| inReady | output | 1 | Input beat accepted this cycle |
| inData | input | LANES | Input activation chunk |
| outValid | output | 1 | Output beat valid |
| outReady | input | 1 | Downstream accepts the output beat |
| outBits | output | PES | Activations of one neuron group |

## Verification
Random weight matrices, thresholds and vectors are fed with random gaps on both streams. This separates correct replay of the stored vector from any reliance on upstream resending, and it exercises stalls that arrive exactly at a group's last beat. A continuous-flow run with both streams always open measures beat spacing, which exposes lost cycles at vector boundaries. An all-zero weight matrix driven with all-zero and all-one vectors reaches the extreme counts `COLS` and 0. Thresholds placed at zero, at the count and one above it tell an unsigned "at least" compare apart from "greater than" or a signed compare.

// File: rtl/bmv_pkg.sv
package bmv_pkg;
  typedef struct packed {
    logic step;       // one tile slot is processed this cycle
    logic firstBeat;  // tile column 0 of the current neuron group
    logic lastBeat;   // final tile column of the current neuron group
    logic liveInput;  // first neuron group: bits come from the input stream
  } bmvCtl_t;
endpackage

// File: rtl/bmv_ctrl.sv
module bmv_ctrl
  import bmv_pkg::*;
#(
  parameter int NF = 4,
  parameter int SF = 4,
  localparam int CW = $clog2(SF),
  localparam int GW = $clog2(NF)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  output logic          inReady,
  output logic          outValid,
  input  logic          outReady,
  output bmvCtl_t       ctl,
  output logic [CW-1:0] chunkIdx,
  output logic [GW-1:0] groupIdx
);
  logic stallOut;

  always_comb begin
    ctl.firstBeat = (chunkIdx == '0);
    ctl.lastBeat  = (chunkIdx == CW'(SF - 1));
    ctl.liveInput = (groupIdx == '0);
    // a finished group cannot retire while the previous beat is still unread
    stallOut      = ctl.lastBeat && outValid && !outReady;
    inReady       = ctl.liveInput && !stallOut;
    ctl.step      = !stallOut && (ctl.liveInput ? inValid : 1'b1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chunkIdx <= '0;
      groupIdx <= '0;
      outValid <= 1'b0;
    end else begin
      if (ctl.step) begin
        chunkIdx <= ctl.lastBeat ? '0 : chunkIdx + 1'b1;
        if (ctl.lastBeat)
          groupIdx <= (groupIdx == GW'(NF - 1)) ? '0 : groupIdx + 1'b1;
      end
      if (ctl.step && ctl.lastBeat) outValid <= 1'b1;
      else if (outReady)            outValid <= 1'b0;
    end
  end
endmodule

// File: rtl/bmv_pe.sv
module bmv_pe #(
  parameter int LANES = 4,
  parameter int NF    = 4,
  parameter int SF    = 4,
  parameter int TW    = 5,
  localparam int CW = $clog2(SF),
  localparam int GW = $clog2(NF),
  localparam int AW = $clog2(NF * SF)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             step,
  input  logic             firstBeat,
  input  logic [CW-1:0]    chunkIdx,
  input  logic [GW-1:0]    groupIdx,
  input  logic [LANES-1:0] vecBits,
  input  logic             wgtWe,
  input  logic [AW-1:0]    wgtAddr,
  input  logic [LANES-1:0] wgtData,
  input  logic             thrWe,
  input  logic [GW-1:0]    thrAddr,
  input  logic [TW-1:0]    thrData,
  output logic             actBit
);
  logic [LANES-1:0] wMem [NF*SF];
  logic [TW-1:0]    thrMem [NF];
  logic [TW-1:0]    acc, pc, total;
  logic [LANES-1:0] match;
  logic [AW-1:0]    rdAddr;

  always_ff @(posedge clk) begin
    if (wgtWe) wMem[wgtAddr]   <= wgtData;
    if (thrWe) thrMem[thrAddr] <= thrData;
  end

  always_comb begin
    rdAddr = AW'(groupIdx) * AW'(SF) + AW'(chunkIdx);
    match  = ~(wMem[rdAddr] ^ vecBits);
    pc     = '0;
    for (int l = 0; l < LANES; l++) pc = pc + TW'(match[l]);
    total  = (firstBeat ? '0 : acc) + pc;
    actBit = (total >= thrMem[groupIdx]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     acc <= '0;
    else if (step) acc <= total;
  end
endmodule

// File: rtl/bmv_datapath.sv
module bmv_datapath
  import bmv_pkg::*;
#(
  parameter int ROWS  = 8,
  parameter int COLS  = 16,
  parameter int PES   = 2,
  parameter int LANES = 4,
  localparam int NF = ROWS / PES,
  localparam int SF = COLS / LANES,
  localparam int TW = $clog2(COLS) + 1,
  localparam int RW = $clog2(ROWS),
  localparam int CW = $clog2(SF),
  localparam int GW = $clog2(NF),
  localparam int AW = $clog2(NF * SF)
) (
  input  logic             clk,
  input  logic             rstN,
  input  bmvCtl_t          ctl,
  input  logic [CW-1:0]    chunkIdx,
  input  logic [GW-1:0]    groupIdx,
  input  logic [LANES-1:0] inData,
  input  logic             wgtWe,
  input  logic [RW-1:0]    wgtRow,
  input  logic [CW-1:0]    wgtChunk,
  input  logic [LANES-1:0] wgtData,
  input  logic             thrWe,
  input  logic [RW-1:0]    thrRow,
  input  logic [TW-1:0]    thrData,
  output logic [PES-1:0]   outBits
);
  logic [LANES-1:0] replayBuf [SF];
  logic [LANES-1:0] vecBits;
  logic [PES-1:0]   actBits;
  logic [GW-1:0]    wgtGroup, thrGroup;
  logic [AW-1:0]    wgtAddr;

  always_comb begin
    vecBits  = ctl.liveInput ? inData : replayBuf[chunkIdx];
    wgtGroup = GW'(32'(wgtRow) / PES);
    thrGroup = GW'(32'(thrRow) / PES);
    wgtAddr  = AW'(wgtGroup) * AW'(SF) + AW'(wgtChunk);
  end

  always_ff @(posedge clk) begin
    if (ctl.step && ctl.liveInput) replayBuf[chunkIdx] <= inData;
  end

  for (genvar p = 0; p < PES; p++) begin : g_pe
    logic peWgtWe, peThrWe;
    assign peWgtWe = wgtWe && ((32'(wgtRow) % PES) == p);
    assign peThrWe = thrWe && ((32'(thrRow) % PES) == p);
    bmv_pe #(.LANES(LANES), .NF(NF), .SF(SF), .TW(TW)) u_pe (
      .clk      (clk),
      .rstN     (rstN),
      .step     (ctl.step),
      .firstBeat(ctl.firstBeat),
      .chunkIdx (chunkIdx),
      .groupIdx (groupIdx),
      .vecBits  (vecBits),
      .wgtWe    (peWgtWe),
      .wgtAddr  (wgtAddr),
      .wgtData  (wgtData),
      .thrWe    (peThrWe),
      .thrAddr  (thrGroup),
      .thrData  (thrData),
      .actBit   (actBits[p])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          outBits <= '0;
    else if (ctl.step && ctl.lastBeat)  outBits <= actBits;
  end
endmodule

// File: rtl/bmv_unit.sv
module bmv_unit
  import bmv_pkg::*;
#(
  parameter int ROWS  = 8,
  parameter int COLS  = 16,
  parameter int PES   = 2,
  parameter int LANES = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        wgtWe,
  input  logic [$clog2(ROWS)-1:0]     wgtRow,
  input  logic [$clog2(COLS/LANES)-1:0] wgtChunk,
  input  logic [LANES-1:0]            wgtData,
  input  logic                        thrWe,
  input  logic [$clog2(ROWS)-1:0]     thrRow,
  input  logic [$clog2(COLS):0]       thrData,
  input  logic                        inValid,
  output logic                        inReady,
  input  logic [LANES-1:0]            inData,
  output logic                        outValid,
  input  logic                        outReady,
  output logic [PES-1:0]              outBits
);
  localparam int NF = ROWS / PES;
  localparam int SF = COLS / LANES;
  localparam int CW = $clog2(SF);
  localparam int GW = $clog2(NF);

  bmvCtl_t       ctl;
  logic [CW-1:0] chunkIdx;
  logic [GW-1:0] groupIdx;

  bmv_ctrl #(.NF(NF), .SF(SF)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .outValid(outValid), .outReady(outReady), .ctl(ctl),
    .chunkIdx(chunkIdx), .groupIdx(groupIdx)
  );

  bmv_datapath #(.ROWS(ROWS), .COLS(COLS), .PES(PES), .LANES(LANES)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .chunkIdx(chunkIdx), .groupIdx(groupIdx),
    .inData(inData), .wgtWe(wgtWe), .wgtRow(wgtRow), .wgtChunk(wgtChunk),
    .wgtData(wgtData), .thrWe(thrWe), .thrRow(thrRow), .thrData(thrData),
    .outBits(outBits)
  );
endmodule

// File: rtl/bmv_unit_chk.sv
module bmv_unit_chk #(
  parameter int ROWS  = 8,
  parameter int COLS  = 16,
  parameter int PES   = 2,
  parameter int LANES = 4
) (
  input logic           clk,
  input logic           rstN,
  input logic           inValid,
  input logic           inReady,
  input logic           outValid,
  input logic           outReady,
  input logic [PES-1:0] outBits
);
  localparam int SF = COLS / LANES;
  localparam int NF = ROWS / PES;

  if (ROWS % PES != 0) begin : g_bad_rows
    initial $error("ROWS must be a multiple of PES");
  end
  if (COLS % LANES != 0) begin : g_bad_cols
    initial $error("COLS must be a multiple of LANES");
  end
  if (SF < 2 || NF < 2) begin : g_bad_fold
    initial $error("both folds must be at least 2");
  end

  int  inCnt;
  logic seenFull;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inCnt    <= 0;
      seenFull <= 1'b0;
    end else if (inValid && inReady) begin
      inCnt <= (inCnt == SF - 1) ? 0 : inCnt + 1;
      if (inCnt == SF - 1) seenFull <= 1'b1;
    end
  end

  // R8: reset clears the output stream
  a_r8_reset_idle: assert property (@(posedge clk) !rstN |=> !outValid);

  // R6: a stalled beat is held unchanged
  a_r6_hold_beat: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outBits));

  // R4: the last input beat of a vector closes the input for the replay groups
  a_r4_replay_closed: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady && (inCnt == SF - 1) |=> !inReady);

  // R2: no group result exists before a whole vector has been taken
  a_r2_full_vector_first: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> seenFull);

  // R1: a presented result is fully defined
  a_r1_bits_known: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !$isunknown(outBits));
endmodule

bind bmv_unit bmv_unit_chk #(.ROWS(ROWS), .COLS(COLS), .PES(PES), .LANES(LANES)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
  .outValid(outValid), .outReady(outReady), .outBits(outBits)
);

// File: tb/bmv_unit_tb.sv
module bmv_unit_tb;
  localparam int ROWS  = 8;
  localparam int COLS  = 16;
  localparam int PES   = 2;
  localparam int LANES = 4;
  localparam int NF = ROWS / PES;
  localparam int SF = COLS / LANES;
  localparam int TW = $clog2(COLS) + 1;
  localparam int RW = $clog2(ROWS);
  localparam int CW = $clog2(SF);
  localparam int NVMAX = 64;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             wgtWe = 1'b0, thrWe = 1'b0;
  logic [RW-1:0]    wgtRow = '0, thrRow = '0;
  logic [CW-1:0]    wgtChunk = '0;
  logic [LANES-1:0] wgtData = '0;
  logic [TW-1:0]    thrData = '0;
  logic             inValid = 1'b0;
  logic             inReady;
  logic [LANES-1:0] inData = '0;
  logic             outValid;
  logic             outReady = 1'b0;
  logic [PES-1:0]   outBits;

  int tests = 0, fails = 0;
  bit [COLS-1:0] wModel [ROWS];
  bit [TW-1:0]   thrModel [ROWS];
  bit [COLS-1:0] vecs [NVMAX];

  always #2 clk = ~clk;

  bmv_unit #(.ROWS(ROWS), .COLS(COLS), .PES(PES), .LANES(LANES)) u_dut (
    .clk(clk), .rstN(rstN), .wgtWe(wgtWe), .wgtRow(wgtRow), .wgtChunk(wgtChunk),
    .wgtData(wgtData), .thrWe(thrWe), .thrRow(thrRow), .thrData(thrData),
    .inValid(inValid), .inReady(inReady), .inData(inData),
    .outValid(outValid), .outReady(outReady), .outBits(outBits)
  );

  function automatic bit expBit(bit [COLS-1:0] v, int row);
    int cnt = 0;
    for (int c = 0; c < COLS; c++) cnt += (wModel[row][c] == v[c]) ? 1 : 0;
    return cnt >= int'(thrModel[row]);
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic loadAll();
    for (int r = 0; r < ROWS; r++) begin
      for (int k = 0; k < SF; k++) begin
        @(negedge clk);
        wgtWe = 1'b1; wgtRow = RW'(r); wgtChunk = CW'(k);
        wgtData = wModel[r][k*LANES +: LANES];   // R3 chunk layout
      end
      @(negedge clk);
      wgtWe = 1'b0; thrWe = 1'b1; thrRow = RW'(r); thrData = thrModel[r];
    end
    @(negedge clk);
    wgtWe = 1'b0; thrWe = 1'b0;
  endtask

  // streams nVec vectors; pIn/pOut are percent chances of valid/ready
  task automatic runBatch(int nVec, int pIn, int pOut, string tag, bit gapCheck);
    int inPtr = 0, sIdx = 0, outCnt = 0, cyc = 0, lastOut = -1;
    bit stalled = 1'b0;
    logic [PES-1:0] heldBits = '0;
    while (outCnt < nVec * NF && cyc < 20000) begin
      @(negedge clk);
      inValid  = (inPtr < nVec) && (($urandom % 100) < pIn);
      inData   = vecs[inPtr < nVec ? inPtr : 0][sIdx*LANES +: LANES];
      outReady = (($urandom % 100) < pOut);
      #1;
      if (stalled) begin
        check(outValid && outBits == heldBits, "R6 held beat",
              int'({outValid, outBits}), int'({1'b1, heldBits}));
      end
      if (inValid && inReady) begin
        if (sIdx == SF - 1) begin sIdx = 0; inPtr++; end
        else sIdx++;
      end
      if (outValid && outReady) begin
        logic [PES-1:0] e;
        int vi = outCnt / NF;
        int g  = outCnt % NF;
        for (int p = 0; p < PES; p++) e[p] = expBit(vecs[vi], g*PES + p);
        check(outBits == e, {tag, " R1 R2 beat"}, int'(outBits), int'(e));
        if (gapCheck && lastOut >= 0)
          check(cyc - lastOut == SF, "R5 beat spacing", cyc - lastOut, SF);
        lastOut = cyc;
        outCnt++;
      end
      stalled  = outValid && !outReady;
      heldBits = outBits;
      cyc++;
    end
    check(outCnt == nVec * NF, {tag, " R2 beat count"}, outCnt, nVec * NF);
    @(negedge clk);
    inValid = 1'b0; outReady = 1'b0;
  endtask

  initial begin
    repeat (int'($urandom(32'h5eed)) % 1) @(negedge clk);
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R8 outValid in reset", int'(outValid), 0);
    check(inReady == 1'b1, "R8 inReady in reset", int'(inReady), 1);
    @(negedge clk);
    rstN = 1'b1;

    // random matrix, thresholds around the midpoint
    for (int r = 0; r < ROWS; r++) begin
      wModel[r]   = COLS'($urandom);
      thrModel[r] = TW'(COLS/2 - 3 + int'($urandom % 7));
    end
    loadAll();

    // continuous flow: R5 spacing plus R1/R2 content
    for (int i = 0; i < 4; i++) vecs[i] = COLS'($urandom);
    runBatch(4, 100, 100, "flow", 1'b1);

    // random gaps on both sides: R4 replay, R6 backpressure
    for (int i = 0; i < 40; i++) vecs[i] = COLS'($urandom);
    runBatch(40, 60, 55, "random", 1'b0);

    // R7 boundaries: zero weights, thresholds at COLS, COLS+1 and 0
    for (int r = 0; r < ROWS; r++) begin
      wModel[r]   = '0;
      thrModel[r] = (r % 3 == 0) ? TW'(COLS) : (r % 3 == 1) ? TW'(COLS + 1) : '0;
    end
    loadAll();
    vecs[0] = '0;   // all match, count COLS
    vecs[1] = '1;   // no match, count 0
    runBatch(2, 80, 70, "R7 edge", 1'b0);

    // R7 at an interior count: equal and one above
    for (int r = 0; r < ROWS; r++) begin
      wModel[r]   = COLS'($urandom);
      thrModel[r] = '0;
    end
    vecs[0] = COLS'($urandom);
    for (int r = 0; r < ROWS; r++) begin
      int cnt = 0;
      for (int c = 0; c < COLS; c++) cnt += (wModel[r][c] == vecs[0][c]) ? 1 : 0;
      thrModel[r] = TW'(cnt + (r % 2));
    end
    loadAll();
    runBatch(1, 100, 100, "R7 equal", 1'b0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule